// File: doc/BRIEF.md
# Character-Row Interrupt Generator

This block keeps track of which scan line of the current character row the display is drawing, and raises a one-cycle non-maskable interrupt request once per row so that the processor can supply the start address of the next row in time. A line strobe advances a scan-line index that runs from 0 up to the last line of the row. When it wraps, it returns to a reload value, which is 0 unless the processor has loaded another start line. The index sits on its last value for the whole final scan line, and a row carry is high during that line. The interrupt is the rising edge of that carry, gated by the vertical sync level and by a kill bit.

The kill bit comes out of reset set, so no interrupt can reach the processor while software is still locating vertical sync. Software watches a status output that reflects the sync level. Once it has found the sync position, it writes the kill bit to zero. While vertical sync is active (the low level of the sync input), requests are also held off. All pins are plain control and status signals; no stream data passes through the block, so there is no handshake and no back-pressure.

Top module: `row_irq_gen`

## Requirements
- R1: A synchronous reset (rst high) sets line_idx to 0, row_carry to 0, nmi to 0 and sync_seen to 0. It also sets the kill bit and makes the reload value 0.
- R2: A line_tick with no valid preload moves line_idx up by one while line_idx is below LINES-1 (9 by default). Without a tick or a valid preload, line_idx holds its value.
- R3: row_carry is high exactly when line_idx equals LINES-1. A line_tick at that value, with no valid preload, sets line_idx to the reload value, which is 0 after reset.
- R4: preload_we with preload_val at most LINES-1 sets line_idx to preload_val on the next cycle and makes preload_val the new reload value. This takes priority over line_tick in the same cycle.
- R5: preload_we with preload_val greater than LINES-1 changes neither line_idx nor the reload value. A line_tick in the same cycle still acts as in R2 and R3.
- R6: The request gate is true when three conditions hold at once: row_carry is high, the registered vsync_n is 1, and the kill bit is 0. nmi is high for one cycle, in the first cycle the gate is true after a cycle in which it was false, so each row yields at most one pulse.
- R7: nmi stays 0 in any cycle where vsync_n was 0 on the previous clock edge.
- R8: kill_we loads the kill bit from kill_wdata. While the kill bit is 1, nmi stays 0. Clearing it while row_carry is high and sync is inactive produces a pulse in the next cycle.
- R9: sync_seen equals the inverse of vsync_n as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_tick | input | 1 | One-cycle strobe at each horizontal line boundary |
| vsync_n | input | 1 | Vertical sync level, low while sync is active |
| preload_we | input | 1 | Processor write strobe for the scan-line start value |
| preload_val | input | CW | Start scan line to load (CW = clog2(LINES)) |
| kill_we | input | 1 | Processor write strobe for the kill bit |
| kill_wdata | input | 1 | New kill bit value, 1 blocks interrupts |
| line_idx | output | CW | Current scan line within the character row |
| row_carry | output | 1 | High during the last scan line of the row |
| nmi | output | 1 | One-cycle non-maskable interrupt request |
| sync_seen | output | 1 | Registered vertical sync status for software polling |

## Verification
The hardest case to reach is a gate that rises without the counter moving onto its last line. Two stimuli do it here. In one, the kill bit is cleared while the index is already parked on the last line. In the other, a preload puts the index straight onto LINES-1. Each requires the counter to be steered and held in place while the kill bit or the preload strobe changes. The bench reaches both with directed sequences: ticks stop on line 9 before the kill write, and a preload of 9 is issued in a cycle where sync is inactive. After that, a long run with random ticks, sync levels, preloads (some out of range) and kill writes is compared against a behavioural model on every clock.

// File: rtl/row_irq_pkg.sv
package row_irq_pkg;
  // What the scan-line counter does on a given clock
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_WRAP = 2'd2,
    CNT_LOAD = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/scan_line_counter.sv
module scan_line_counter
  import row_irq_pkg::*;
#(
  parameter int LINES = 10,
  parameter int CW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ld_we,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] idx,
  output logic          carry
);
  localparam logic [CW-1:0] LAST = CW'(LINES - 1);

  logic [CW-1:0] idx_q;
  logic [CW-1:0] reload_q;
  logic          ld_ok;
  cnt_op_e       op;

  assign ld_ok = ld_we && (ld_val <= LAST);

  always_comb begin
    if (ld_ok)              op = CNT_LOAD;
    else if (!tick)         op = CNT_HOLD;
    else if (idx_q == LAST) op = CNT_WRAP;
    else                    op = CNT_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      reload_q <= '0;
    end else begin
      unique case (op)
        CNT_LOAD: begin
          idx_q    <= ld_val;
          reload_q <= ld_val;
        end
        CNT_WRAP: idx_q <= reload_q;
        CNT_STEP: idx_q <= idx_q + CW'(1);
        default:  idx_q <= idx_q;
      endcase
    end
  end

  assign idx   = idx_q;
  assign carry = (idx_q == LAST);

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST) else $error("index out of range"); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_ok && idx_q != LAST) |=> idx_q == $past(idx_q) + CW'(1))
    else $error("step failed"); // R2
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_ok && idx_q == LAST) |=> idx_q == $past(reload_q))
    else $error("wrap failed"); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    ld_ok |=> idx_q == $past(ld_val)) else $error("load failed"); // R4
  AST_BAD_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ld_we && !ld_ok && !tick) |=> ($stable(idx_q) && $stable(reload_q)))
    else $error("bad load acted"); // R5
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic carry,
  input  logic vsync_n,
  input  logic kill_we,
  input  logic kill_wdata,
  output logic nmi,
  output logic sync_seen
);
  logic vs_q;
  logic kill_q;
  logic gate;
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q   <= 1'b1;
      kill_q <= 1'b1;
      gate_q <= 1'b0;
    end else begin
      vs_q   <= vsync_n;
      gate_q <= gate;
      if (kill_we) kill_q <= kill_wdata;
    end
  end

  assign gate      = carry && vs_q && !kill_q;
  assign nmi       = gate && !gate_q;
  assign sync_seen = !vs_q;

  AST_KILL_MASKS: assert property (@(posedge clk) disable iff (rst)
    kill_q |-> !nmi) else $error("nmi while killed"); // R8
  AST_SYNC_MASKS: assert property (@(posedge clk) disable iff (rst)
    !vs_q |-> !nmi) else $error("nmi during sync"); // R7
  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (rst)
    nmi |=> !nmi) else $error("nmi longer than one cycle"); // R6
  AST_NMI_NEEDS_CARRY: assert property (@(posedge clk) disable iff (rst)
    nmi |-> carry) else $error("nmi without carry"); // R6
  AST_SYNC_TRACK: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sync_seen == !$past(vsync_n)) else $error("sync status lag"); // R9
endmodule

// File: rtl/row_irq_gen.sv
module row_irq_gen #(
  parameter int LINES = 10,
  parameter int CW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_tick,
  input  logic          vsync_n,
  input  logic          preload_we,
  input  logic [CW-1:0] preload_val,
  input  logic          kill_we,
  input  logic          kill_wdata,
  output logic [CW-1:0] line_idx,
  output logic          row_carry,
  output logic          nmi,
  output logic          sync_seen
);
  logic carry_w;

  scan_line_counter #(.LINES(LINES), .CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (line_tick),
    .ld_we  (preload_we),
    .ld_val (preload_val),
    .idx    (line_idx),
    .carry  (carry_w)
  );

  irq_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .carry      (carry_w),
    .vsync_n    (vsync_n),
    .kill_we    (kill_we),
    .kill_wdata (kill_wdata),
    .nmi        (nmi),
    .sync_seen  (sync_seen)
  );

  assign row_carry = carry_w;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!nmi && line_idx == '0)) else $error("reset state"); // R1
endmodule

// File: tb/sim_row_irq_gen.sv
module sim_row_irq_gen;
  localparam int LINES = 10;
  localparam int CW    = $clog2(LINES);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_tick = 1'b0;
  logic          vsync_n = 1'b1;
  logic          preload_we = 1'b0;
  logic [CW-1:0] preload_val = '0;
  logic          kill_we = 1'b0;
  logic          kill_wdata = 1'b0;
  logic [CW-1:0] line_idx;
  logic          row_carry;
  logic          nmi;
  logic          sync_seen;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  row_irq_gen #(.LINES(LINES), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .line_tick(line_tick), .vsync_n(vsync_n),
    .preload_we(preload_we), .preload_val(preload_val),
    .kill_we(kill_we), .kill_wdata(kill_wdata),
    .line_idx(line_idx), .row_carry(row_carry), .nmi(nmi), .sync_seen(sync_seen)
  );

  // Behavioural reference state
  int m_cnt = 0, m_reload = 0, m_kill = 1, m_vs = 1, m_gprev = 0;

  function automatic int m_gate();
    return (m_cnt == LINES - 1 && m_vs == 1 && m_kill == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int g;
    g = m_gate();
    if (rst) begin
      m_cnt = 0; m_reload = 0; m_kill = 1; m_vs = 1; m_gprev = 0;
    end else begin
      m_gprev = g;
      m_vs = vsync_n ? 1 : 0;
      if (kill_we) m_kill = kill_wdata ? 1 : 0;
      if (preload_we && int'(preload_val) < LINES) begin
        m_cnt = int'(preload_val);
        m_reload = int'(preload_val);
      end else if (line_tick) begin
        m_cnt = (m_cnt == LINES - 1) ? m_reload : m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_compare();
    check("R2", "line_idx model", int'(line_idx), m_cnt);
    check("R3", "row_carry model", int'(row_carry), (m_cnt == LINES - 1) ? 1 : 0);
    check("R6", "nmi model", int'(nmi), (m_gate() == 1 && m_gprev == 0) ? 1 : 0);
    check("R9", "sync_seen model", int'(sync_seen), m_vs ? 0 : 1);
  endtask

  // Drive inputs for one clock, then compare at the following falling edge
  task automatic cyc(input bit tk, input bit vs, input bit pw, input int pv,
                     input bit kw, input bit kd);
    line_tick = tk; vsync_n = vs; preload_we = pw; preload_val = CW'(pv);
    kill_we = kw; kill_wdata = kd;
    @(negedge clk);
    model_compare();
    line_tick = 1'b0; preload_we = 1'b0; kill_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "line_idx after reset", int'(line_idx), 0);
    check("R1", "row_carry after reset", int'(row_carry), 0);
    check("R1", "nmi after reset", int'(nmi), 0);
    check("R1", "sync_seen after reset", int'(sync_seen), 0);

    // Kill still set from reset: reach line 9, no request (R8)
    for (int i = 0; i < 9; i++) cyc(1, 1, 0, 0, 0, 0);
    check("R2", "line_idx after nine ticks", int'(line_idx), 9);
    check("R3", "carry on last line", int'(row_carry), 1);
    check("R8", "nmi while killed", int'(nmi), 0);
    // Clear kill while carry high: pulse next cycle (R8)
    cyc(0, 1, 0, 0, 1, 0);
    check("R8", "nmi after kill clear", int'(nmi), 1);
    cyc(0, 1, 0, 0, 0, 0);
    check("R6", "nmi one cycle only", int'(nmi), 0);
    cyc(1, 1, 0, 0, 0, 0);
    check("R3", "wrap to zero", int'(line_idx), 0);

    // Preload 3 with a tick in the same cycle: load wins (R4)
    cyc(1, 1, 1, 3, 0, 0);
    check("R4", "preload value taken", int'(line_idx), 3);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, 0);
    check("R6", "nmi on row end", int'(nmi), 1);
    cyc(1, 1, 0, 0, 0, 0);
    check("R3", "wrap to reload", int'(line_idx), 3);
    // Out-of-range preload ignored (R5)
    cyc(0, 1, 1, 12, 0, 0);
    check("R5", "bad preload no effect", int'(line_idx), 3);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0);
    check("R5", "reload kept after bad preload", int'(line_idx), 3);

    // Sync active: no request at row end (R7)
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 0);
    check("R7", "carry during sync", int'(row_carry), 1);
    check("R7", "nmi during sync", int'(nmi), 0);
    check("R9", "sync_seen during sync", int'(sync_seen), 1);
    cyc(1, 0, 0, 0, 0, 0);
    // Preload straight to the last line with sync inactive (R4, R6)
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 1, 9, 0, 0);
    check("R4", "preload to last line", int'(line_idx), 9);
    check("R6", "nmi from preload to last line", int'(nmi), 1);
    cyc(0, 1, 1, 0, 0, 0);

    // Random traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom_range(0, 2) == 0), ($urandom_range(0, 7) != 0),
          ($urandom_range(0, 40) == 0), $urandom_range(0, 15),
          ($urandom_range(0, 60) == 0), ($urandom_range(0, 3) == 0));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule